// File: doc/BRIEF.md
# Scaler Coefficient RAM Loader

This block fills the polyphase coefficient store of an image scaler. A single start pulse hands it one configuration job. The job gives the luma and chroma tap counts for the horizontal and vertical directions, a flag that enables chroma filters, and a sharpness factor for each direction. The block works out which filters need loading. For each of them it issues one tap-select strobe, then reads coefficients from a synchronous source memory. It writes them two taps at a time into the bank that is not in use.

Only the first half of the phase range, plus the centre phase, is written. The remaining phases are mirror images and are left to the scaler datapath. When every selected filter is written, the block flips the active bank in one step, so the scaler never sees a half-written table. A direction whose luma and chroma tap counts are both 2 uses fixed built-in coefficients. For that direction the block raises a flag instead of loading anything.

The engine takes three cycles per tap pair: even read, odd read, write. A full eight-tap filter costs about 400 cycles, well inside a vertical blanking interval.

Top module: `sclcoef_loader`

## Requirements
- R1: Filters are loaded in a fixed slot order: luma horizontal (type code 1), luma vertical (code 0), chroma horizontal (code 3), chroma vertical (code 2). The chroma slots load only when `chroma_en` is 1. Codes 4 and 5 are reserved for alpha vertical and alpha horizontal.
- R2: Before the first data write of each filter, `sel_load` pulses for one cycle with `wr_phase`=0, `wr_pair`=0 and `wr_ftype` set to that filter's code.
- R3: For a filter of T taps, one write is made for each phase 0 to NUM_PHASES/2 and each pair 0 to (T+1)/2-1. The pair index runs fastest, and it returns to 0 when the phase advances.
- R4: The even word of pair k at phase p comes from source address p*T+2k, and the odd word comes from address p*T+2k+1. Both reads present the filter's type code on `src_ftype`. Read data arrives one cycle after `src_rd`.
- R5: When 2k+1 is not less than T, the odd word is written as zero. `wr_even_en` and `wr_odd_en` are both 1 on every write.
- R6: Bits 1:0 of every written even and odd word are zero.
- R7: Every data write targets the bank opposite to `active_bank`.
- R8: A direction is fixed when its luma and chroma tap counts are both exactly 2. No filter of a fixed direction is loaded and its `*_fixed` flag is 1. Its `*_sharp` flag is 1 only if it is fixed and its sharpness factor is nonzero. The flags hold until the next accepted start.
- R9: After the last filter of a job is written, `active_bank` inverts. If a job loads nothing, `active_bank` is unchanged.
- R10: `done` is a one-cycle pulse in the cycle after the bank swap, and `active_bank` already shows the new value in that cycle. `busy` is 1 from the cycle after an accepted start through the `done` cycle, and 0 the cycle after.
- R11: A start pulse while `busy` is 1 is ignored. It does not change the job, the flags or the write sequence.
- R12: After reset, `busy`, `done`, `wr_en`, `sel_load`, `active_bank` and all four flags are 0.
- R13: A slot whose tap count is 0 or greater than 8 is skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Job start pulse |
| h_taps | input | 4 | Luma horizontal tap count |
| h_taps_c | input | 4 | Chroma horizontal tap count |
| v_taps | input | 4 | Luma vertical tap count |
| v_taps_c | input | 4 | Chroma vertical tap count |
| chroma_en | input | 1 | Load chroma filters |
| h_sharp_factor | input | 3 | Horizontal sharpness factor |
| v_sharp_factor | input | 3 | Vertical sharpness factor |
| src_rd | output | 1 | Source memory read strobe |
| src_ftype | output | 3 | Filter type for the read |
| src_addr | output | 9 | Source coefficient index |
| src_data | input | 14 | Source read data, one cycle after `src_rd` |
| sel_load | output | 1 | Tap-select initialisation strobe |
| wr_en | output | 1 | Coefficient write strobe |
| wr_bank | output | 1 | Bank being written |
| wr_ftype | output | 3 | Filter type code |
| wr_phase | output | 6 | Phase index |
| wr_pair | output | 2 | Tap-pair index |
| wr_even | output | 14 | Even tap word |
| wr_even_en | output | 1 | Even word enable |
| wr_odd | output | 14 | Odd tap word |
| wr_odd_en | output | 1 | Odd word enable |
| active_bank | output | 1 | Bank used by the scaler |
| h_fixed | output | 1 | Horizontal uses fixed 2-tap coefficients |
| v_fixed | output | 1 | Vertical uses fixed 2-tap coefficients |
| h_sharp | output | 1 | Horizontal sharpening on |
| v_sharp | output | 1 | Vertical sharpening on |
| busy | output | 1 | Job in progress |
| done | output | 1 | Job complete pulse |

## Verification
A wrong phase, pair or row-base counter shows up at once as a misplaced write index or source address. Its effect then spreads to every later write of that filter, so it appears within three cycles of the fault. A corrupted pending-slot mask or job register changes the order of `sel_load` strobes or the total write count, and this is visible by the end of the job. A bank register fault is seen either in `wr_bank` matching `active_bank` on the first write, or in a missing or extra flip at `done`.

// File: rtl/sclcoef_pkg.sv
package sclcoef_pkg;

    localparam int TAPS_W    = 4;
    localparam int FT_W      = 3;
    localparam int NUM_SLOTS = 4;
    localparam int SLOT_W    = 2;

    typedef enum logic [FT_W-1:0] {
        FT_LUMA_V   = 3'd0,
        FT_LUMA_H   = 3'd1,
        FT_CHROMA_V = 3'd2,
        FT_CHROMA_H = 3'd3,
        FT_ALPHA_V  = 3'd4,
        FT_ALPHA_H  = 3'd5
    } ftype_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_NEXT,
        S_SEL,
        S_RD_E,
        S_RD_O,
        S_WR,
        S_SWAP,
        S_DONE
    } state_e;

    typedef struct packed {
        logic [NUM_SLOTS-1:0][TAPS_W-1:0] taps;
        logic [NUM_SLOTS-1:0]             pending;
        logic                             any_load;
    } job_t;

    typedef struct packed {
        logic h_fixed;
        logic v_fixed;
        logic h_sharp;
        logic v_sharp;
    } mode_t;

    // Slot order: luma H, luma V, chroma H, chroma V
    function automatic ftype_e slot_ftype(input logic [SLOT_W-1:0] slot);
        case (slot)
            2'd0:    return FT_LUMA_H;
            2'd1:    return FT_LUMA_V;
            2'd2:    return FT_CHROMA_H;
            default: return FT_CHROMA_V;
        endcase
    endfunction

    function automatic logic [SLOT_W-1:0] first_slot(input logic [NUM_SLOTS-1:0] m);
        logic [SLOT_W-1:0] r;
        r = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (m[i]) r = SLOT_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/sclcoef_job_decode.sv
module sclcoef_job_decode
    import sclcoef_pkg::*;
#(
    parameter int MAX_TAPS = 8,
    parameter int SHARP_W  = 3
) (
    input  logic [NUM_SLOTS-1:0][TAPS_W-1:0] slot_taps,
    input  logic                             chroma_en,
    input  logic [SHARP_W-1:0]               h_factor,
    input  logic [SHARP_W-1:0]               v_factor,
    output logic [NUM_SLOTS-1:0]             load_mask,
    output mode_t                            mode
);
    logic [NUM_SLOTS-1:0] in_range;
    logic                 h_fix;
    logic                 v_fix;

    genvar g;
    generate
        for (g = 0; g < NUM_SLOTS; g++) begin : g_range
            assign in_range[g] = (slot_taps[g] != '0) &&
                                 (slot_taps[g] <= TAPS_W'(MAX_TAPS));
        end
    endgenerate

    // slot 0 = luma H, 1 = luma V, 2 = chroma H, 3 = chroma V
    assign h_fix = (slot_taps[0] == TAPS_W'(2)) && (slot_taps[2] == TAPS_W'(2));
    assign v_fix = (slot_taps[1] == TAPS_W'(2)) && (slot_taps[3] == TAPS_W'(2));

    always_comb begin
        load_mask[0] = in_range[0] && !h_fix;
        load_mask[1] = in_range[1] && !v_fix;
        load_mask[2] = in_range[2] && !h_fix && chroma_en;
        load_mask[3] = in_range[3] && !v_fix && chroma_en;
        mode.h_fixed = h_fix;
        mode.v_fixed = v_fix;
        mode.h_sharp = h_fix && (h_factor != '0);
        mode.v_sharp = v_fix && (v_factor != '0);
    end

endmodule

// File: rtl/sclcoef_index_walk.sv
module sclcoef_index_walk
    import sclcoef_pkg::*;
#(
    parameter int NUM_PHASES = 64,
    parameter int PHASE_W    = 6,
    parameter int PAIR_W     = 2,
    parameter int ADDR_W     = 9
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               step,
    input  logic [TAPS_W-1:0]  taps,
    output logic [PHASE_W-1:0] phase,
    output logic [PAIR_W-1:0]  pair,
    output logic [ADDR_W-1:0]  even_addr,
    output logic               has_odd,
    output logic               last
);
    localparam int LAST_PHASE = NUM_PHASES / 2;

    logic [ADDR_W-1:0] row_base;
    logic [TAPS_W-1:0] n_pairs;
    logic              last_pair;

    assign n_pairs   = (taps + TAPS_W'(1)) >> 1;
    assign last_pair = (TAPS_W'(pair) == n_pairs - TAPS_W'(1));
    assign last      = last_pair && (phase == PHASE_W'(LAST_PHASE));
    assign even_addr = row_base + ADDR_W'({pair, 1'b0});
    assign has_odd   = TAPS_W'({pair, 1'b1}) < taps;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            phase    <= '0;
            pair     <= '0;
            row_base <= '0;
        end else if (step) begin
            if (last_pair) begin
                pair     <= '0;
                phase    <= phase + PHASE_W'(1);
                row_base <= row_base + ADDR_W'(taps);
            end else begin
                pair <= pair + PAIR_W'(1);
            end
        end
    end

endmodule

// File: rtl/sclcoef_bank_ctl.sv
module sclcoef_bank_ctl (
    input  logic clk,
    input  logic rst,
    input  logic swap,
    output logic active_bank,
    output logic idle_bank
);
    always_ff @(posedge clk) begin
        if (rst)       active_bank <= 1'b0;
        else if (swap) active_bank <= ~active_bank;
    end

    assign idle_bank = ~active_bank;

endmodule

// File: rtl/sclcoef_loader.sv
module sclcoef_loader
    import sclcoef_pkg::*;
#(
    parameter int MAX_TAPS   = 8,
    parameter int NUM_PHASES = 64,
    parameter int COEF_W     = 14,
    parameter int SHARP_W    = 3,
    parameter int PHASE_W    = $clog2(NUM_PHASES),
    parameter int PAIR_W     = $clog2(MAX_TAPS / 2),
    parameter int ADDR_W     = $clog2((NUM_PHASES / 2 + 1) * MAX_TAPS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [TAPS_W-1:0]  h_taps,
    input  logic [TAPS_W-1:0]  h_taps_c,
    input  logic [TAPS_W-1:0]  v_taps,
    input  logic [TAPS_W-1:0]  v_taps_c,
    input  logic               chroma_en,
    input  logic [SHARP_W-1:0] h_sharp_factor,
    input  logic [SHARP_W-1:0] v_sharp_factor,
    output logic               src_rd,
    output logic [FT_W-1:0]    src_ftype,
    output logic [ADDR_W-1:0]  src_addr,
    input  logic [COEF_W-1:0]  src_data,
    output logic               sel_load,
    output logic               wr_en,
    output logic               wr_bank,
    output logic [FT_W-1:0]    wr_ftype,
    output logic [PHASE_W-1:0] wr_phase,
    output logic [PAIR_W-1:0]  wr_pair,
    output logic [COEF_W-1:0]  wr_even,
    output logic               wr_even_en,
    output logic [COEF_W-1:0]  wr_odd,
    output logic               wr_odd_en,
    output logic               active_bank,
    output logic               h_fixed,
    output logic               v_fixed,
    output logic               h_sharp,
    output logic               v_sharp,
    output logic               busy,
    output logic               done
);
    localparam logic [COEF_W-1:0] LSB_CLR = ~COEF_W'(3);

    state_e                           state;
    job_t                             job;
    mode_t                            mode_q;
    mode_t                            mode_d;
    logic [NUM_SLOTS-1:0]             mask_d;
    logic [NUM_SLOTS-1:0][TAPS_W-1:0] taps_in;
    logic [SLOT_W-1:0]                cur_slot;
    logic [TAPS_W-1:0]                cur_taps;
    ftype_e                           cur_ft;
    logic [COEF_W-1:0]                even_q;
    logic [ADDR_W-1:0]                even_addr;
    logic                             has_odd;
    logic                             last;
    logic                             idle_bank;

    assign taps_in = {v_taps_c, h_taps_c, v_taps, h_taps};

    sclcoef_job_decode #(
        .MAX_TAPS (MAX_TAPS),
        .SHARP_W  (SHARP_W)
    ) decode_i (
        .slot_taps (taps_in),
        .chroma_en (chroma_en),
        .h_factor  (h_sharp_factor),
        .v_factor  (v_sharp_factor),
        .load_mask (mask_d),
        .mode      (mode_d)
    );

    assign cur_taps = job.taps[cur_slot];
    assign cur_ft   = slot_ftype(cur_slot);

    sclcoef_index_walk #(
        .NUM_PHASES (NUM_PHASES),
        .PHASE_W    (PHASE_W),
        .PAIR_W     (PAIR_W),
        .ADDR_W     (ADDR_W)
    ) walk_i (
        .clk       (clk),
        .rst       (rst),
        .clear     (state == S_NEXT),
        .step      (state == S_WR),
        .taps      (cur_taps),
        .phase     (wr_phase),
        .pair      (wr_pair),
        .even_addr (even_addr),
        .has_odd   (has_odd),
        .last      (last)
    );

    sclcoef_bank_ctl bank_i (
        .clk         (clk),
        .rst         (rst),
        .swap        (state == S_SWAP),
        .active_bank (active_bank),
        .idle_bank   (idle_bank)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            job      <= '0;
            mode_q   <= '0;
            cur_slot <= '0;
            even_q   <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (start) begin
                        job.taps     <= taps_in;
                        job.pending  <= mask_d;
                        job.any_load <= |mask_d;
                        mode_q       <= mode_d;
                        state        <= S_NEXT;
                    end
                end
                S_NEXT: begin
                    if (|job.pending) begin
                        cur_slot                         <= first_slot(job.pending);
                        job.pending[first_slot(job.pending)] <= 1'b0;
                        state                            <= S_SEL;
                    end else begin
                        state <= job.any_load ? S_SWAP : S_DONE;
                    end
                end
                S_SEL:  state <= S_RD_E;
                S_RD_E: state <= S_RD_O;
                S_RD_O: begin
                    even_q <= src_data & LSB_CLR;
                    state  <= S_WR;
                end
                S_WR:   state <= last ? S_NEXT : S_RD_E;
                S_SWAP: state <= S_DONE;
                S_DONE: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        src_rd    = (state == S_RD_E) || ((state == S_RD_O) && has_odd);
        src_addr  = (state == S_RD_O) ? even_addr + ADDR_W'(1) : even_addr;
        src_ftype = cur_ft;
        sel_load  = (state == S_SEL);
        wr_en     = (state == S_WR);
        wr_even_en = wr_en;
        wr_odd_en  = wr_en;
        wr_bank   = idle_bank;
        wr_ftype  = cur_ft;
        wr_even   = even_q;
        wr_odd    = has_odd ? (src_data & LSB_CLR) : '0;
        busy      = (state != S_IDLE);
        done      = (state == S_DONE);
        h_fixed   = mode_q.h_fixed;
        v_fixed   = mode_q.v_fixed;
        h_sharp   = mode_q.h_sharp;
        v_sharp   = mode_q.v_sharp;
    end

endmodule

// File: rtl/sclcoef_loader_chk.sv
module sclcoef_loader_chk #(
    parameter int PH_MAX  = 32,
    parameter int PHASE_W = 6,
    parameter int PAIR_W  = 2,
    parameter int COEF_W  = 14
) (
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic               sel_load,
    input logic               wr_en,
    input logic               wr_bank,
    input logic [PHASE_W-1:0] wr_phase,
    input logic [PAIR_W-1:0]  wr_pair,
    input logic [COEF_W-1:0]  wr_even,
    input logic [COEF_W-1:0]  wr_odd,
    input logic               active_bank,
    input logic               h_fixed,
    input logic               v_fixed,
    input logic               h_sharp,
    input logic               v_sharp,
    input logic               busy,
    input logic               done
);
    a_r2_sel_origin: assert property (@(posedge clk) disable iff (rst)
        sel_load |-> (wr_phase == '0) && (wr_pair == '0) && !wr_en);

    a_r3_phase_bound: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_phase <= PHASE_W'(PH_MAX)));

    a_r6_low_bits: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_even[1:0] == 2'b00) && (wr_odd[1:0] == 2'b00));

    a_r7_idle_bank: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_bank != active_bank));

    a_r9_swap_at_done: assert property (@(posedge clk) disable iff (rst)
        !$stable(active_bank) |-> done);

    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && !busy);

    a_r10_busy_with_done: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    a_r11_flags_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable({h_fixed, v_fixed, h_sharp, v_sharp}));

endmodule

bind sclcoef_loader sclcoef_loader_chk #(
    .PH_MAX  (NUM_PHASES / 2),
    .PHASE_W (PHASE_W),
    .PAIR_W  (PAIR_W),
    .COEF_W  (COEF_W)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .sel_load    (sel_load),
    .wr_en       (wr_en),
    .wr_bank     (wr_bank),
    .wr_phase    (wr_phase),
    .wr_pair     (wr_pair),
    .wr_even     (wr_even),
    .wr_odd      (wr_odd),
    .active_bank (active_bank),
    .h_fixed     (h_fixed),
    .v_fixed     (v_fixed),
    .h_sharp     (h_sharp),
    .v_sharp     (v_sharp),
    .busy        (busy),
    .done        (done)
);

// File: tb/sclcoef_loader_tb_top.sv
`timescale 1ns/1ps
module sclcoef_loader_tb_top;

    localparam int LASTP = 32;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst, start, chroma_en;
    logic [3:0]  h_taps, h_taps_c, v_taps, v_taps_c;
    logic [2:0]  h_sharp_factor, v_sharp_factor;
    logic        src_rd, sel_load, wr_en, wr_bank, wr_even_en, wr_odd_en;
    logic [2:0]  src_ftype, wr_ftype;
    logic [8:0]  src_addr;
    logic [13:0] src_data, wr_even, wr_odd;
    logic [5:0]  wr_phase;
    logic [1:0]  wr_pair;
    logic        active_bank, h_fixed, v_fixed, h_sharp, v_sharp, busy, done;

    sclcoef_loader dut_i (
        .clk(clk), .rst(rst), .start(start),
        .h_taps(h_taps), .h_taps_c(h_taps_c), .v_taps(v_taps), .v_taps_c(v_taps_c),
        .chroma_en(chroma_en), .h_sharp_factor(h_sharp_factor), .v_sharp_factor(v_sharp_factor),
        .src_rd(src_rd), .src_ftype(src_ftype), .src_addr(src_addr), .src_data(src_data),
        .sel_load(sel_load), .wr_en(wr_en), .wr_bank(wr_bank), .wr_ftype(wr_ftype),
        .wr_phase(wr_phase), .wr_pair(wr_pair), .wr_even(wr_even), .wr_even_en(wr_even_en),
        .wr_odd(wr_odd), .wr_odd_en(wr_odd_en), .active_bank(active_bank),
        .h_fixed(h_fixed), .v_fixed(v_fixed), .h_sharp(h_sharp), .v_sharp(v_sharp),
        .busy(busy), .done(done)
    );

    function automatic logic [13:0] cf(input int ft, input int a);
        return 14'(ft * 1031 + a * 37 + 3);
    endfunction

    // synchronous source memory model
    always @(posedge clk) if (src_rd) src_data <= cf(int'(src_ftype), int'(src_addr));

    int n_checks = 0, n_err = 0;
    int n_wr, n_sel, n_done;
    int rec_ft[1024], rec_ph[1024], rec_pr[1024], rec_ev[1024], rec_od[1024];
    int rec_bk[1024], rec_en[1024];
    int sel_ft[8], sel_at[8], sel_org[8];

    always @(negedge clk) begin
        if (!rst) begin
            if (wr_en && n_wr < 1024) begin
                rec_ft[n_wr] = int'(wr_ftype);
                rec_ph[n_wr] = int'(wr_phase);
                rec_pr[n_wr] = int'(wr_pair);
                rec_ev[n_wr] = int'(wr_even);
                rec_od[n_wr] = int'(wr_odd);
                rec_bk[n_wr] = int'(wr_bank);
                rec_en[n_wr] = int'({wr_even_en, wr_odd_en});
                n_wr++;
            end
            if (sel_load && n_sel < 8) begin
                sel_ft[n_sel]  = int'(wr_ftype);
                sel_at[n_sel]  = n_wr;
                sel_org[n_sel] = int'(wr_phase) + int'(wr_pair);
                n_sel++;
            end
            if (done) n_done++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; start = 1'b0; chroma_en = 1'b0;
        h_taps = '0; h_taps_c = '0; v_taps = '0; v_taps_c = '0;
        h_sharp_factor = '0; v_sharp_factor = '0;
        n_wr = 0; n_sel = 0; n_done = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done, "R12", "busy/done after reset", int'({busy, done}), 0);
        chk(!wr_en && !sel_load, "R12", "write strobes after reset", int'({wr_en, sel_load}), 0);
        chk(!active_bank, "R12", "active_bank after reset", int'(active_bank), 0);
        chk({h_fixed, v_fixed, h_sharp, v_sharp} == 4'b0, "R12", "flags after reset",
            int'({h_fixed, v_fixed, h_sharp, v_sharp}), 0);
    endtask

    task automatic run_job(input int h, input int hc, input int v, input int vc,
                           input bit ce, input int hs, input int vs, input bit inject);
        int bank0, cyc, k, si, anyl;
        int tp[4];
        int ftc[4];
        bit ld[4];
        bit hfix, vfix;
        tp = '{h, v, hc, vc};
        ftc = '{1, 0, 3, 2};
        hfix = (h == 2) && (hc == 2);
        vfix = (v == 2) && (vc == 2);
        for (int s = 0; s < 4; s++) ld[s] = (tp[s] >= 1) && (tp[s] <= 8);
        ld[0] = ld[0] && !hfix;
        ld[1] = ld[1] && !vfix;
        ld[2] = ld[2] && !hfix && ce;
        ld[3] = ld[3] && !vfix && ce;
        anyl = int'(ld[0] | ld[1] | ld[2] | ld[3]);

        @(negedge clk);
        bank0 = int'(active_bank);
        n_wr = 0; n_sel = 0; n_done = 0;
        h_taps = 4'(h); h_taps_c = 4'(hc); v_taps = 4'(v); v_taps_c = 4'(vc);
        chroma_en = ce; h_sharp_factor = 3'(hs); v_sharp_factor = 3'(vs);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R10", "busy after start", int'(busy), 1);
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            if (inject && cyc == 20) begin
                // R11: a second start with different settings while busy
                start = 1'b1; h_taps = 4'd2; h_taps_c = 4'd2; v_taps = 4'd2; v_taps_c = 4'd2;
                h_sharp_factor = 3'd7; v_sharp_factor = 3'd7; chroma_en = 1'b1;
            end
            if (inject && cyc == 21) start = 1'b0;
        end
        chk(cyc < 5000, "R10", "done reached", cyc, 0);
        chk(int'(active_bank) == (bank0 ^ anyl), "R9", "bank at done",
            int'(active_bank), bank0 ^ anyl);
        @(negedge clk);
        chk(!busy && !done, "R10", "busy/done after done", int'({busy, done}), 0);
        chk(n_done == 1, "R10", "done pulse count", n_done, 1);
        chk(int'(active_bank) == (bank0 ^ anyl), "R9", "bank after job",
            int'(active_bank), bank0 ^ anyl);

        k = 0; si = 0;
        for (int s = 0; s < 4; s++) begin
            if (ld[s]) begin
                chk(si < n_sel && sel_ft[si] == ftc[s], "R1", "select type order",
                    sel_ft[si], ftc[s]);
                chk(si < n_sel && sel_at[si] == k && sel_org[si] == 0, "R2",
                    "select before data", sel_at[si], k);
                si++;
                for (int p = 0; p <= LASTP; p++) begin
                    for (int pr = 0; pr < (tp[s] + 1) / 2; pr++) begin
                        int ee, oo;
                        ee = int'(cf(ftc[s], p * tp[s] + 2 * pr) & 14'h3ffc);
                        oo = (2 * pr + 1 < tp[s]) ?
                             int'(cf(ftc[s], p * tp[s] + 2 * pr + 1) & 14'h3ffc) : 0;
                        if (k < n_wr) begin
                            chk(rec_ft[k] == ftc[s] && rec_ph[k] == p && rec_pr[k] == pr,
                                "R3", "write index", rec_ph[k] * 16 + rec_pr[k], p * 16 + pr);
                            chk(rec_ev[k] == ee, "R4", "even word (R6 low bits)", rec_ev[k], ee);
                            chk(rec_od[k] == oo, "R5", "odd word (R6 low bits)", rec_od[k], oo);
                            chk(rec_en[k] == 3, "R5", "both enables", rec_en[k], 3);
                            chk(rec_bk[k] == (bank0 ^ 1), "R7", "write bank", rec_bk[k], bank0 ^ 1);
                        end
                        k++;
                    end
                end
            end
        end
        chk(n_wr == k, "R3", "total writes (R13 skips)", n_wr, k);
        chk(n_sel == si, "R2", "select strobe count", n_sel, si);
        chk(h_fixed == hfix && v_fixed == vfix, "R8", "fixed flags (R11 hold)",
            int'({h_fixed, v_fixed}), int'({hfix, vfix}));
        chk(h_sharp == (hfix && hs != 0) && v_sharp == (vfix && vs != 0), "R8",
            "sharp flags", int'({h_sharp, v_sharp}),
            int'({hfix && hs != 0, vfix && vs != 0}));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL R10 watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin
        t_reset();
        run_job(8, 4, 5, 3, 1'b0, 3, 2, 1'b0);   // R1 luma only, odd padding on 5 taps
        run_job(3, 4, 6, 1, 1'b1, 0, 0, 1'b0);   // R1 all four slots, 1-tap chroma
        run_job(2, 2, 4, 4, 1'b1, 3, 5, 1'b0);   // R8 horizontal fixed, sharp on
        run_job(2, 2, 2, 2, 1'b1, 0, 5, 1'b0);   // R9 nothing loaded, no swap
        run_job(7, 2, 0, 9, 1'b1, 1, 1, 1'b0);   // R13 out-of-range taps skipped
        run_job(6, 6, 8, 8, 1'b0, 4, 4, 1'b1);   // R11 start ignored while busy
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

endmodule